// File: doc/BRIEF.md
# GPIO interrupt trigger router

The router picks twelve interrupt sources out of a pool of 128 GPIO pad inputs and turns each into a level interrupt request for a downstream interrupt controller. Every output line has its own 7-bit source index into the pad pool and its own trigger mode. A line can be level-sensitive (active high or active low), edge-triggered on rising or falling transitions, or fire on both transitions. An edge event appears on the output as a single-cycle pulse.

All pads are brought into the clock domain through a two-stage synchroniser before any mode logic looks at them. Software programs the block through a small synchronous register bus with eight word addresses. A global enable holds every output low while it is clear. The edge history stays live while the enable is clear, and a write that reconfigures a line suppresses that line's edge detector for one cycle. Enabling the block or retargeting a line therefore never creates a phantom edge.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset all twelve outputs are low and every register address reads back zero.
- R2: Register map, by word address. Address 0 holds the global enable in bit 31, the per-line single-edge bits in bits 12..23 and the per-line active-low bits in bits 0..11. Addresses 1 to 6 each hold two 7-bit source indices: bits 6..0 for line 2(X-1) and bits 22..16 for line 2(X-1)+1. Address 7 holds the per-line both-edge bits in bits 0..11. Unimplemented bits read as zero.
- R3: Output line k follows the pad whose index equals its 7-bit source field, with no effect from other pads.
- R4: With single-edge, both-edge and active-low all clear, a line is high while its synchronised pad is high, three clock edges after the pad changes.
- R5: With active-low set and single-edge and both-edge clear, a line is high while its pad is low.
- R6: With single-edge set and active-low clear, a rising pad transition gives exactly one high output cycle, three clock edges after the transition. A falling transition gives nothing.
- R7: With single-edge and active-low both set, a falling transition gives one high cycle and a rising transition gives nothing.
- R8: With the both-edge bit set, every pad transition gives a one-cycle pulse, whatever the single-edge and active-low bits hold.
- R9: While the global enable is clear all outputs stay low. Edges seen while disabled are not reported, and setting the enable while a pad is already high produces no pulse.
- R10: Changing a line's source index or mode creates no pulse, even when the old and new pads differ in level.
- R11: Read data is registered: it appears one clock edge after a cycle with the read strobe high, and it holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 128 | Asynchronous GPIO pad levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 12 | Interrupt request lines |

## Verification
A pad change is due on an output three clock edges later: two synchroniser stages, then the output register. A register write takes effect at the edge that samples it, and read data is due at the first edge after the strobe. The bench drives every input on a falling clock edge and counts exactly three falling edges after a pad change before it samples. For edge modes it samples once more one cycle later to confirm that the pulse has ended. Reconfiguration and enable tests sample every cycle over a window longer than the pipeline, so a late phantom pulse cannot escape.

// File: rtl/girt_pkg.sv
package girt_pkg;

    localparam int NUM_LINES    = 12;
    localparam int SEL_W        = 7;
    localparam int NUM_PADS     = 1 << SEL_W;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int NUM_SEL_REGS = NUM_LINES / 2;

    // bit positions that software and this block must agree on
    localparam int EN_BIT      = 31;
    localparam int SINGLE_LSB  = 12;
    localparam int POL_LSB     = 0;
    localparam int BOTH_LSB    = 0;
    localparam int HI_SEL_LSB  = 16;
    localparam int LO_SEL_LSB  = 0;

    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_BOTH = ADDR_W'(7);

    typedef struct packed {
        logic [SEL_W-1:0] src;     // pad index
        logic             act_low; // low level / falling edge
        logic             edge_md; // edge-triggered when set
        logic             dual;    // both transitions, overrides the others
    } line_cfg_t;

    // trigger decision for one line; hush masks edge events only
    function automatic logic trig_hit(input logic act_low, input logic edge_md,
                                      input logic dual, input logic prev,
                                      input logic cur, input logic hush);
        logic hit;
        if (dual)
            hit = (prev ^ cur) & ~hush;
        else if (edge_md)
            hit = (act_low ? (prev & ~cur) : (~prev & cur)) & ~hush;
        else
            hit = cur ^ act_low;
        return hit;
    endfunction

endpackage

// File: rtl/girt_sync_bank.sv
module girt_sync_bank #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/girt_regs.sv
module girt_regs
    import girt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output line_cfg_t         cfg_o [NUM_LINES],
    output logic              glob_en_o,
    output logic [NUM_LINES-1:0] reload_o
);
    logic                 en_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] single_q;
    logic [NUM_LINES-1:0] both_q;
    logic [SEL_W-1:0]     src_q [NUM_LINES];
    logic [NUM_LINES-1:0] reload_q;
    logic [DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]    rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            pol_q    <= '0;
            single_q <= '0;
            both_q   <= '0;
            for (int k = 0; k < NUM_LINES; k++) src_q[k] <= '0;
        end else if (wr_en) begin
            if (addr == ADR_CTRL) begin
                en_q     <= wdata[EN_BIT];
                single_q <= wdata[SINGLE_LSB +: NUM_LINES];
                pol_q    <= wdata[POL_LSB +: NUM_LINES];
            end
            if (addr == ADR_BOTH)
                both_q <= wdata[BOTH_LSB +: NUM_LINES];
            for (int j = 0; j < NUM_SEL_REGS; j++) begin
                if (addr == ADDR_W'(j + 1)) begin
                    src_q[2*j]   <= wdata[LO_SEL_LSB +: SEL_W];
                    src_q[2*j+1] <= wdata[HI_SEL_LSB +: SEL_W];
                end
            end
        end
    end

    // one-cycle edge suppression for every line a write can reconfigure
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else begin
            for (int k = 0; k < NUM_LINES; k++)
                reload_q[k] <= wr_en && (addr == ADR_CTRL || addr == ADR_BOTH ||
                                         addr == ADDR_W'(k / 2 + 1));
        end
    end

    always_comb begin
        rd_word = '0;
        if (addr == ADR_CTRL) begin
            rd_word[EN_BIT]                  = en_q;
            rd_word[SINGLE_LSB +: NUM_LINES] = single_q;
            rd_word[POL_LSB +: NUM_LINES]    = pol_q;
        end else if (addr == ADR_BOTH) begin
            rd_word[BOTH_LSB +: NUM_LINES]   = both_q;
        end else begin
            for (int j = 0; j < NUM_SEL_REGS; j++) begin
                if (addr == ADDR_W'(j + 1)) begin
                    rd_word[LO_SEL_LSB +: SEL_W] = src_q[2*j];
                    rd_word[HI_SEL_LSB +: SEL_W] = src_q[2*j+1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfg
            assign cfg_o[g].src     = src_q[g];
            assign cfg_o[g].act_low = pol_q[g];
            assign cfg_o[g].edge_md = single_q[g];
            assign cfg_o[g].dual    = both_q[g];
        end
    endgenerate

    assign rdata     = rdata_q;
    assign glob_en_o = en_q;
    assign reload_o  = reload_q;
endmodule

// File: rtl/girt_line.sv
module girt_line
    import girt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic glob_en,
    input  logic act_low,
    input  logic edge_md,
    input  logic dual,
    input  logic reload,
    input  logic cur,
    output logic irq
);
    logic prev_q;
    logic irq_q;

    // history follows the selected pad every cycle, enabled or not
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= cur;
            irq_q  <= glob_en & trig_hit(act_low, edge_md, dual, prev_q, cur, reload);
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import girt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PADS-1:0]  pad_i,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [NUM_PADS-1:0]  pad_sync;
    line_cfg_t            cfg [NUM_LINES];
    logic                 glob_en;
    logic [NUM_LINES-1:0] reload_v;
    logic [NUM_LINES-1:0] pol_v;
    logic [NUM_LINES-1:0] single_v;
    logic [NUM_LINES-1:0] both_v;
    logic [NUM_LINES-1:0] cur_v;

    girt_sync_bank #(.WIDTH(NUM_PADS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pad_i),
        .sync_o  (pad_sync)
    );

    girt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .cfg_o     (cfg),
        .glob_en_o (glob_en),
        .reload_o  (reload_v)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign cur_v[g]    = pad_sync[cfg[g].src];
            assign pol_v[g]    = cfg[g].act_low;
            assign single_v[g] = cfg[g].edge_md;
            assign both_v[g]   = cfg[g].dual;

            girt_line u_line (
                .clk     (clk),
                .rst     (rst),
                .glob_en (glob_en),
                .act_low (pol_v[g]),
                .edge_md (single_v[g]),
                .dual    (both_v[g]),
                .reload  (reload_v[g]),
                .cur     (cur_v[g]),
                .irq     (irq_o[g])
            );
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
    import girt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_LINES-1:0] irq_o,
    input logic                 glob_en,
    input logic [NUM_LINES-1:0] pol_v,
    input logic [NUM_LINES-1:0] single_v,
    input logic [NUM_LINES-1:0] both_v,
    input logic [NUM_LINES-1:0] cur_v,
    input logic [NUM_LINES-1:0] reload_v
);
    a_r1_reset_low: assert property (@(posedge clk) rst |=> irq_o == '0);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> irq_o == '0);

    a_r2_sel_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != ADR_CTRL && addr != ADR_BOTH) |=> (rdata & 32'hFF80_FF80) == '0);

    a_r2_both_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADR_BOTH) |=> rdata[DATA_W-1:NUM_LINES] == '0);

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
            a_r4_level_high: assert property (@(posedge clk) disable iff (rst)
                (glob_en && !single_v[g] && !both_v[g] && !pol_v[g] && cur_v[g]) |=> irq_o[g]);

            a_r5_level_low: assert property (@(posedge clk) disable iff (rst)
                (glob_en && !single_v[g] && !both_v[g] && pol_v[g] && !cur_v[g]) |=> irq_o[g]);

            a_r8_dual_fires: assert property (@(posedge clk) disable iff (rst)
                (glob_en && both_v[g] && !reload_v[g] && (cur_v[g] != $past(cur_v[g]))) |=> irq_o[g]);

            a_r6_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
                (irq_o[g] && $past(single_v[g] && !both_v[g]) && single_v[g] && !both_v[g])
                |=> !irq_o[g]);
        end
    endgenerate
endmodule

bind gpio_irq_router gpio_irq_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq_o    (irq_o),
    .glob_en  (glob_en),
    .pol_v    (pol_v),
    .single_v (single_v),
    .both_v   (both_v),
    .cur_v    (cur_v),
    .reload_v (reload_v)
);

// File: tb/gpio_irq_router_tb.sv
`timescale 1ns/1ps
module gpio_irq_router_tb;
    import girt_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NUM_PADS-1:0]  pads = '0;
    logic                 wr_en = 1'b0;
    logic                 rd_en = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [DATA_W-1:0]    wdata = '0;
    logic [DATA_W-1:0]    rdata;
    logic [NUM_LINES-1:0] irq;

    int checks = 0;
    int fails  = 0;

    gpio_irq_router u_dut (
        .clk   (clk),
        .rst   (rst),
        .pad_i (pads),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq)
    );

    always #10 clk = ~clk;

    // {act_low, single, both, before, after, expected_pre, expected_first, expected_second}
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        8'b000_01_0_11,  // level high, 0->1
        8'b000_10_1_00,  // level high, 1->0
        8'b100_01_1_00,  // level low, 0->1
        8'b100_10_0_11,  // level low, 1->0
        8'b010_01_0_10,  // rising, 0->1
        8'b010_10_0_00,  // rising, 1->0
        8'b110_10_0_10,  // falling, 1->0
        8'b110_01_0_00,  // falling, 0->1
        8'b111_01_0_10,  // both, overrides falling
        8'b001_10_0_10,  // both, overrides level high
        8'b101_10_0_10,  // both, overrides level low
        8'b011_01_0_10   // both, overrides rising
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check("R1 irq after reset", 32'(irq), 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(ADDR_W'(a), d);
            check("R1 register reset value", d, 32'h0);
        end

        // R11: read data holds while the strobe is low
        wr(ADR_BOTH, 32'h0000_0ABC);
        idle(2);
        check("R11 rdata holds without read", rdata, 32'h0);
        rd(ADR_BOTH, d);
        check("R11 rdata after one edge", d, 32'h0000_0ABC);
        wr(ADR_BOTH, 32'h0);

        // R2: implemented bits per address
        for (int a = 0; a < 8; a++) begin
            wr(ADDR_W'(a), 32'hFFFF_FFFF);
            rd(ADDR_W'(a), d);
            if (a == 0)      check("R2 control mask", d, 32'h80FF_FFFF);
            else if (a == 7) check("R2 both-edge mask", d, 32'h0000_0FFF);
            else             check("R2 selector mask", d, 32'h007F_007F);
            wr(ADDR_W'(a), 32'h0);
        end
        idle(4);

        // R4..R8: trigger mode vectors on line 0, source pad 5
        wr(ADDR_W'(1), 32'd5);
        for (int v = 0; v < NV; v++) begin
            logic [7:0] e;
            string tag;
            e = VEC[v];
            if (e[5])      tag = "R8 both-edge";
            else if (e[6]) tag = e[7] ? "R7 falling" : "R6 rising";
            else           tag = e[7] ? "R5 level low" : "R4 level high";
            wr(ADR_CTRL, 32'h8000_0000 | (32'(e[6]) << SINGLE_LSB) | 32'(e[7]));
            wr(ADR_BOTH, 32'(e[5]));
            pads[5] = e[4];
            idle(6);
            check({tag, " settled"}, 32'(irq[0]), 32'(e[2]));
            pads[5] = e[3];
            idle(3);
            check({tag, " first cycle"}, 32'(irq[0]), 32'(e[1]));
            idle(1);
            check({tag, " second cycle"}, 32'(irq[0]), 32'(e[0]));
        end
        pads = '0;
        wr(ADR_BOTH, 32'h0);

        // R3: routing through both halves of selector words
        wr(ADR_CTRL, 32'h8000_0000);
        wr(ADDR_W'(1), 32'h0);
        wr(ADDR_W'(2), (32'd100 << 16) | 32'd20);
        pads[100] = 1'b1;
        idle(3);
        check("R3 line 3 from pad 100", 32'(irq), 32'h008);
        pads[20] = 1'b1;
        idle(3);
        check("R3 line 2 from pad 20", 32'(irq), 32'h00C);
        wr(ADDR_W'(6), 32'd127 << 16);
        pads[127] = 1'b1;
        idle(3);
        check("R3 line 11 from pad 127", 32'(irq), 32'h80C);
        pads = '0;
        wr(ADDR_W'(2), 32'h0);
        wr(ADDR_W'(6), 32'h0);
        idle(4);

        // R9: global enable gating
        wr(ADDR_W'(1), 32'd5);
        wr(ADR_CTRL, 32'h0);
        pads[5] = 1'b1;
        idle(4);
        check("R9 level held low while disabled", 32'(irq), 32'h0);
        wr(ADR_CTRL, 32'h0000_1000);
        pads[5] = 1'b0;
        idle(4);
        pads[5] = 1'b1;
        idle(3);
        check("R9 edge while disabled", 32'(irq[0]), 32'h0);
        wr(ADR_CTRL, 32'h8000_1000);
        for (int c = 0; c < 4; c++) begin
            check("R9 no pulse on enable", 32'(irq[0]), 32'h0);
            idle(1);
        end
        pads[5] = 1'b0;
        idle(3);
        pads[5] = 1'b1;
        idle(3);
        check("R9 edge after enable", 32'(irq[0]), 32'h1);

        // R10: retarget a rising-edge line from a low pad to a high pad
        pads = '0;
        wr(ADDR_W'(1), 32'd10);
        pads[11] = 1'b1;
        idle(4);
        wr(ADDR_W'(1), 32'd11);
        for (int c = 0; c < 5; c++) begin
            check("R10 no pulse on source change", 32'(irq[0]), 32'h0);
            idle(1);
        end
        pads[11] = 1'b0;
        idle(3);
        pads[11] = 1'b1;
        idle(3);
        check("R10 new source live", 32'(irq[0]), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule